// File: doc/BRIEF.md
# Serial Flash Busy-Status Poller

This block waits for a serial NOR flash to finish an internal program or erase cycle. After a one-clock start strobe it keeps issuing a status-read frame over single-lane SPI. Each frame carries a one-byte read opcode followed by one byte of returned status. After each frame the block decides whether the device is still busy. Between frames chip select is held high for a programmable idle gap.

The poll ends in one of two ways. If a frame reports the device ready, the block pulses a done output. If the programmed number of polls all come back busy, it pulses a timeout output instead. The block drives the four SPI pins directly.

A mode input, sampled at start, picks the status source. Standard mode reads the main status register, where bit 0 high means busy. Flag mode reads a separate flag register, where bit 7 high means ready. The last status byte read stays on an output. The write-enable latch bit is also shown there, but it plays no part in the completion decision.

Top module: `flash_busy_poller`

## Requirements
- R1: Each poll is one frame with chip select low and exactly 16 SCK pulses. SCK idles low whenever chip select is high. MOSI changes only while SCK is low, and it holds still for the whole time SCK is high (SPI mode 0).
- R2: In standard mode (flag_mode_i = 0 at start), every frame sends opcode 0x05, most significant bit first, on the first 8 SCK rising edges.
- R3: In standard mode the device counts as ready when status bit 0 is 0. Any other bit, bit 7 included, does not affect the decision.
- R4: In flag mode (flag_mode_i = 1 at start), every frame sends opcode 0x70. The device counts as ready when status bit 7 is 1, whatever the value of bit 0.
- R5: The status byte is built from MISO sampled on SCK rising edges 9 to 16, first bit into bit 7. status_o changes only when a frame ends, and it holds while the block is idle. wel_o is status bit 1.
- R6: Between two polls of one run, chip select stays high for at least max(idle_cycles_i, 1) clocks and at most that value plus 3.
- R7: If N consecutive polls are busy, where N = max(timeout_polls_i, 1), the block pulses timeout_o for one clock after the N-th frame. It starts no further frame and does not pulse done_o.
- R8: After the first ready poll, done_o pulses for exactly one clock and no further frame follows. done_o and timeout_o are never high together.
- R9: busy_o is high from the clock after an accepted start until the done or timeout pulse. A start strobe while busy_o is high is ignored, including any change of the mode input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-clock strobe that begins a poll run |
| flag_mode_i | input | 1 | 0: standard busy-bit polling, 1: flag-register ready-bit polling |
| idle_cycles_i | input | IDLE_W | Minimum chip-select-high clocks between polls |
| timeout_polls_i | input | TMO_W | Maximum number of polls before timeout |
| busy_o | output | 1 | A poll run is in progress |
| done_o | output | 1 | One-clock pulse: device reported ready |
| timeout_o | output | 1 | One-clock pulse: poll limit reached while still busy |
| status_o | output | 8 | Last status byte read |
| wel_o | output | 1 | Write-enable latch bit of the last status byte |
| spi_sck_o | output | 1 | SPI clock |
| spi_cs_n_o | output | 1 | SPI chip select, active low |
| spi_mosi_o | output | 1 | SPI data to the flash |
| spi_miso_i | input | 1 | SPI data from the flash |

## Verification
The bench plays a flash model that returns a programmed busy byte for a set number of frames and then a ready byte. Its test bytes deliberately set the bit the current mode must ignore: bit 7 in standard mode and bit 0 in flag mode. A design that mixed up the two polarities would then stop early or time out. The model also records the opcode and the SCK count of every frame, so a wrong opcode, bit order or frame length shows up as a bad frame. Other scenarios cover timeout at a limit of 0 and of 4, the measured chip-select gap, the width of the done pulse, and a mid-run start strobe carrying a different mode, which a faulty design would use to restart or switch opcode.

// File: rtl/flpoll_pkg.sv
package flpoll_pkg;

   localparam logic [7:0] OP_READ_STATUS = 8'h05;
   localparam logic [7:0] OP_READ_FLAGS  = 8'h70;

   localparam int BUSY_BIT  = 0;
   localparam int LATCH_BIT = 1;
   localparam int READY_BIT = 7;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FRAME,
      ST_GAP
   } poll_state_t;

   function automatic logic dev_ready(input logic flag_mode, input logic [7:0] sts);
      return flag_mode ? sts[READY_BIT] : ~sts[BUSY_BIT];
   endfunction

endpackage

// File: rtl/flpoll_spi_frame.sv
module flpoll_spi_frame #(
   parameter int OP_W    = 8,
   parameter int DAT_W   = 8,
   parameter int CLK_DIV = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_i,
   input  logic [OP_W-1:0]  opcode_i,
   input  logic             miso_i,
   output logic             sck_o,
   output logic             cs_n_o,
   output logic             mosi_o,
   output logic             frame_done_o,
   output logic [DAT_W-1:0] rx_o
);
   localparam int FRAME_BITS = OP_W + DAT_W;
   localparam int BIT_W      = $clog2(FRAME_BITS);
   localparam int DIV_W      = $clog2(CLK_DIV + 1);

   generate
      if (CLK_DIV < 1) begin : g_bad_div
         $error("CLK_DIV must be at least 1");
      end
      if (OP_W < 1 || DAT_W < 1) begin : g_bad_w
         $error("OP_W and DAT_W must be positive");
      end
   endgenerate

   logic             active;
   logic             tick;
   logic [BIT_W-1:0] bitn;
   logic [OP_W-1:0]  txsh;
   logic [DAT_W-1:0] rxsh;

   generate
      if (CLK_DIV == 1) begin : g_div_none
         assign tick = active;
      end else begin : g_div_cnt
         logic [DIV_W-1:0] hcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              hcnt <= '0;
            else if (!active || tick) hcnt <= '0;
            else                      hcnt <= hcnt + 1'b1;
         end
         assign tick = active && (hcnt == DIV_W'(CLK_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active       <= 1'b0;
         sck_o        <= 1'b0;
         cs_n_o       <= 1'b1;
         mosi_o       <= 1'b0;
         frame_done_o <= 1'b0;
         bitn         <= '0;
         txsh         <= '0;
         rxsh         <= '0;
         rx_o         <= '0;
      end else begin
         frame_done_o <= 1'b0;
         if (!active) begin
            if (go_i) begin
               active <= 1'b1;
               cs_n_o <= 1'b0;
               sck_o  <= 1'b0;
               bitn   <= '0;
               mosi_o <= opcode_i[OP_W-1];
               txsh   <= opcode_i << 1;
            end
         end else if (tick) begin
            if (!sck_o) begin
               sck_o <= 1'b1;
               if (bitn >= BIT_W'(OP_W))
                  rxsh <= {rxsh[DAT_W-2:0], miso_i};
            end else begin
               sck_o <= 1'b0;
               if (bitn == BIT_W'(FRAME_BITS - 1)) begin
                  active       <= 1'b0;
                  cs_n_o       <= 1'b1;
                  mosi_o       <= 1'b0;
                  frame_done_o <= 1'b1;
                  rx_o         <= rxsh;
               end else begin
                  bitn   <= bitn + 1'b1;
                  mosi_o <= txsh[OP_W-1];
                  txsh   <= txsh << 1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/flpoll_ctrl.sv
module flpoll_ctrl
   import flpoll_pkg::*;
#(
   parameter int IDLE_W = 8,
   parameter int TMO_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              flag_mode_i,
   input  logic [IDLE_W-1:0] idle_cycles_i,
   input  logic [TMO_W-1:0]  timeout_polls_i,
   input  logic              frame_done_i,
   input  logic [7:0]        rx_i,
   output logic              go_o,
   output logic [7:0]        opcode_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              timeout_o
);
   generate
      if (IDLE_W < 1 || TMO_W < 1) begin : g_bad_w
         $error("IDLE_W and TMO_W must be positive");
      end
   endgenerate

   poll_state_t       state;
   logic              mode_q;
   logic [IDLE_W-1:0] gap_len;
   logic [IDLE_W-1:0] gap_cnt;
   logic [TMO_W-1:0]  limit;
   logic [TMO_W-1:0]  polls;
   logic              last_poll;

   assign busy_o    = (state != ST_IDLE);
   assign opcode_o  = mode_q ? OP_READ_FLAGS : OP_READ_STATUS;
   assign last_poll = ({1'b0, polls} + 1'b1) >= {1'b0, limit};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         mode_q    <= 1'b0;
         gap_len   <= '0;
         gap_cnt   <= '0;
         limit     <= '0;
         polls     <= '0;
         go_o      <= 1'b0;
         done_o    <= 1'b0;
         timeout_o <= 1'b0;
      end else begin
         go_o      <= 1'b0;
         done_o    <= 1'b0;
         timeout_o <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start_i) begin
                  mode_q  <= flag_mode_i;
                  gap_len <= (idle_cycles_i == '0) ? IDLE_W'(1) : idle_cycles_i;
                  limit   <= (timeout_polls_i == '0) ? TMO_W'(1) : timeout_polls_i;
                  polls   <= '0;
                  go_o    <= 1'b1;
                  state   <= ST_FRAME;
               end
            end
            ST_FRAME: begin
               if (frame_done_i) begin
                  if (dev_ready(mode_q, rx_i)) begin
                     done_o <= 1'b1;
                     state  <= ST_IDLE;
                  end else if (last_poll) begin
                     timeout_o <= 1'b1;
                     state     <= ST_IDLE;
                  end else begin
                     polls   <= polls + 1'b1;
                     gap_cnt <= '0;
                     state   <= ST_GAP;
                  end
               end
            end
            ST_GAP: begin
               if (gap_cnt == gap_len - 1'b1) begin
                  go_o  <= 1'b1;
                  state <= ST_FRAME;
               end else begin
                  gap_cnt <= gap_cnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/flash_busy_poller.sv
module flash_busy_poller
   import flpoll_pkg::*;
#(
   parameter int CLK_DIV = 2,
   parameter int IDLE_W  = 8,
   parameter int TMO_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              flag_mode_i,
   input  logic [IDLE_W-1:0] idle_cycles_i,
   input  logic [TMO_W-1:0]  timeout_polls_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              timeout_o,
   output logic [7:0]        status_o,
   output logic              wel_o,
   output logic              spi_sck_o,
   output logic              spi_cs_n_o,
   output logic              spi_mosi_o,
   input  logic              spi_miso_i
);
   logic       go;
   logic [7:0] opcode;
   logic       frame_done;

   flpoll_ctrl #(
      .IDLE_W (IDLE_W),
      .TMO_W  (TMO_W)
   ) u_ctrl (
      .clk             (clk),
      .rst_n           (rst_n),
      .start_i         (start_i),
      .flag_mode_i     (flag_mode_i),
      .idle_cycles_i   (idle_cycles_i),
      .timeout_polls_i (timeout_polls_i),
      .frame_done_i    (frame_done),
      .rx_i            (status_o),
      .go_o            (go),
      .opcode_o        (opcode),
      .busy_o          (busy_o),
      .done_o          (done_o),
      .timeout_o       (timeout_o)
   );

   flpoll_spi_frame #(
      .OP_W    (8),
      .DAT_W   (8),
      .CLK_DIV (CLK_DIV)
   ) u_frame (
      .clk          (clk),
      .rst_n        (rst_n),
      .go_i         (go),
      .opcode_i     (opcode),
      .miso_i       (spi_miso_i),
      .sck_o        (spi_sck_o),
      .cs_n_o       (spi_cs_n_o),
      .mosi_o       (spi_mosi_o),
      .frame_done_o (frame_done),
      .rx_o         (status_o)
   );

   assign wel_o = status_o[LATCH_BIT];
endmodule

// File: rtl/flpoll_checker.sv
module flpoll_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       busy_o,
   input logic       done_o,
   input logic       timeout_o,
   input logic [7:0] status_o,
   input logic       spi_sck_o,
   input logic       spi_cs_n_o,
   input logic       spi_mosi_o
);
   a_r1_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n_o |-> !spi_sck_o);

   a_r1_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sck_o && $past(spi_sck_o)) |-> $stable(spi_mosi_o));

   a_r5_status_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(status_o) |-> $rose(spi_cs_n_o));

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r7_timeout_single: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |=> !timeout_o);

   a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && timeout_o));

   a_r9_end_of_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o || timeout_o) |-> (!busy_o && $past(busy_o)));

   a_r9_frame_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_cs_n_o |-> busy_o);

   a_r7_no_frame_after_end: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o || timeout_o) |=> spi_cs_n_o);
endmodule

bind flash_busy_poller flpoll_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .timeout_o  (timeout_o),
   .status_o   (status_o),
   .spi_sck_o  (spi_sck_o),
   .spi_cs_n_o (spi_cs_n_o),
   .spi_mosi_o (spi_mosi_o)
);

// File: tb/flash_busy_poller_bench.sv
module flash_busy_poller_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       flag_mode_i = 1'b0;
   logic [7:0] idle_cycles_i = 8'd1;
   logic [7:0] timeout_polls_i = 8'd1;
   logic       busy_o, done_o, timeout_o, wel_o;
   logic [7:0] status_o;
   logic       spi_sck_o, spi_cs_n_o, spi_mosi_o;
   logic       spi_miso_i = 1'b0;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_busy_poller u_flash_busy_poller (
      .clk             (clk),
      .rst_n           (rst_n),
      .start_i         (start_i),
      .flag_mode_i     (flag_mode_i),
      .idle_cycles_i   (idle_cycles_i),
      .timeout_polls_i (timeout_polls_i),
      .busy_o          (busy_o),
      .done_o          (done_o),
      .timeout_o       (timeout_o),
      .status_o        (status_o),
      .wel_o           (wel_o),
      .spi_sck_o       (spi_sck_o),
      .spi_cs_n_o      (spi_cs_n_o),
      .spi_mosi_o      (spi_mosi_o),
      .spi_miso_i      (spi_miso_i)
   );

   // flash model
   logic [7:0] m_busy_byte, m_ready_byte, m_exp_op, m_op, m_resp;
   int m_busy_frames, m_frames, m_bits, m_bad_op, m_bad_bits;
   int g_run, g_min, g_max;

   always @(negedge spi_cs_n_o) begin
      m_bits = 0;
      m_op   = 8'h00;
      m_resp = (m_frames < m_busy_frames) ? m_busy_byte : m_ready_byte;
      m_frames++;
   end

   always @(posedge spi_sck_o) begin
      if (!spi_cs_n_o) begin
         if (m_bits < 8) m_op = {m_op[6:0], spi_mosi_o};
         m_bits++;
      end
   end

   always @(negedge spi_sck_o) begin
      if (!spi_cs_n_o && m_bits >= 8 && m_bits < 16)
         spi_miso_i = m_resp[15 - m_bits];
   end

   always @(posedge spi_cs_n_o) begin
      if (m_op != m_exp_op) m_bad_op++;
      if (m_bits != 16) m_bad_bits++;
   end

   always @(negedge clk) begin
      if (busy_o && spi_cs_n_o) g_run++;
      else if (!spi_cs_n_o) begin
         if (g_run > 0 && m_frames > 1) begin
            if (g_run < g_min) g_min = g_run;
            if (g_run > g_max) g_max = g_run;
         end
         g_run = 0;
      end else g_run = 0;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                  req, what, act, act, exp, exp);
      end
   endtask

   task automatic arm(input logic [7:0] busy_b, input logic [7:0] ready_b,
                      input int nbusy, input logic [7:0] op);
      m_busy_byte = busy_b; m_ready_byte = ready_b; m_busy_frames = nbusy;
      m_exp_op = op; m_frames = 0; m_bad_op = 0; m_bad_bits = 0;
      g_run = 0; g_min = 9999; g_max = 0;
   endtask

   task automatic pulse_start(input logic fm, input logic [7:0] idle, input logic [7:0] tmo);
      @(negedge clk);
      flag_mode_i = fm; idle_cycles_i = idle; timeout_polls_i = tmo; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic finish_run(output int nd, output int nt);
      int cyc = 0;
      nd = 0; nt = 0;
      while (busy_o && cyc < 50000) begin @(negedge clk); cyc++; end
      for (int k = 0; k < 8; k++) begin
         if (done_o) nd++;
         if (timeout_o) nt++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      chk(spi_cs_n_o == 1'b1, "R1", "reset cs_n", spi_cs_n_o, 1);
      chk(spi_sck_o == 1'b0, "R1", "reset sck", spi_sck_o, 0);
      chk(busy_o == 1'b0 && done_o == 1'b0 && timeout_o == 1'b0, "R9", "reset flags",
          {busy_o, done_o, timeout_o}, 0);
      chk(status_o == 8'h00, "R5", "reset status", status_o, 0);
   endtask

   task automatic t_std_first_ready();
      int nd, nt;
      arm(8'h01, 8'h80, 0, 8'h05);   // ready byte has bit7 set: ignored in standard mode
      pulse_start(1'b0, 8'd3, 8'd5);
      chk(busy_o == 1'b1, "R9", "busy after start", busy_o, 1);
      finish_run(nd, nt);
      chk(nd == 1, "R8", "done pulse width", nd, 1);
      chk(nt == 0, "R8", "no timeout on ready", nt, 0);
      chk(m_frames == 1, "R3", "frames std first ready", m_frames, 1);
      chk(m_bad_op == 0, "R2", "opcode 0x05 frames bad", m_bad_op, 0);
      chk(m_bad_bits == 0, "R1", "frames without 16 sck", m_bad_bits, 0);
      chk(status_o == 8'h80, "R5", "status byte", status_o, 8'h80);
   endtask

   task automatic t_std_busy_then_ready();
      int nd, nt;
      arm(8'h81, 8'h82, 3, 8'h05);   // busy bit0 set with bit7 set; ready carries write-enable latch
      pulse_start(1'b0, 8'd5, 8'd10);
      finish_run(nd, nt);
      chk(m_frames == 4, "R3", "frames busy x3 then ready", m_frames, 4);
      chk(nd == 1 && nt == 0, "R8", "done after busy polls", nd * 10 + nt, 10);
      chk(m_bad_op == 0, "R2", "opcode frames bad", m_bad_op, 0);
      chk(g_min >= 5, "R6", "min cs gap", g_min, 5);
      chk(g_max <= 8, "R6", "max cs gap", g_max, 8);
      chk(status_o == 8'h82, "R5", "status after ready", status_o, 8'h82);
      chk(wel_o == 1'b1, "R5", "write-enable latch bit shown", wel_o, 1);
      repeat (30) @(negedge clk);
      chk(status_o == 8'h82 && spi_cs_n_o, "R5", "status held while idle", status_o, 8'h82);
   endtask

   task automatic t_flag_mode();
      int nd, nt;
      arm(8'h7F, 8'h01 | 8'h80, 2, 8'h70);   // busy: bit7 clear, bit0 clear-busy meaningless
      pulse_start(1'b1, 8'd0, 8'd10);
      finish_run(nd, nt);
      chk(m_frames == 3, "R4", "flag frames", m_frames, 3);
      chk(m_bad_op == 0, "R4", "opcode 0x70 frames bad", m_bad_op, 0);
      chk(nd == 1 && nt == 0, "R4", "flag done", nd * 10 + nt, 10);
      chk(g_min >= 1 && g_max <= 4, "R6", "gap with idle 0", g_min, 1);
      chk(status_o == 8'h81, "R4", "flag status", status_o, 8'h81);
   endtask

   task automatic t_timeout();
      int nd, nt;
      arm(8'h03, 8'h00, 1000, 8'h05);
      pulse_start(1'b0, 8'd2, 8'd4);
      finish_run(nd, nt);
      chk(m_frames == 4, "R7", "frames before timeout", m_frames, 4);
      chk(nt == 1 && nd == 0, "R7", "timeout pulse, no done", nt * 10 + nd, 10);
      chk(status_o == 8'h03, "R7", "status at timeout", status_o, 8'h03);
      arm(8'h01, 8'h00, 1000, 8'h05);
      pulse_start(1'b0, 8'd2, 8'd0);
      finish_run(nd, nt);
      chk(m_frames == 1 && nt == 1, "R7", "limit 0 acts as 1", m_frames * 10 + nt, 11);
   endtask

   task automatic t_start_ignored();
      int nd, nt;
      arm(8'h01, 8'h00, 2, 8'h05);
      pulse_start(1'b0, 8'd4, 8'd10);
      repeat (40) @(negedge clk);
      flag_mode_i = 1'b1; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      finish_run(nd, nt);
      chk(m_frames == 3, "R9", "frames with mid-run start", m_frames, 3);
      chk(m_bad_op == 0, "R9", "mode kept despite mid-run start", m_bad_op, 0);
      chk(nd == 1, "R9", "single done", nd, 1);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
   end

   initial begin
      arm(8'h00, 8'h00, 0, 8'h05);
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_std_first_ready();
      t_std_busy_then_ready();
      t_flag_mode();
      t_timeout();
      t_start_ignored();
      summary();
   end
endmodule